// File: doc/BRIEF.md
# Transparent Translation Window Matcher

This block decides, for every memory access, whether the access falls inside one of two programmable transparent windows. An access that hits a window skips page translation: its physical address is its logical address. Each window names a range of the top address byte, with per-bit ignore control. It also carries a filter on the 3-bit function code and a filter on the access direction. Each filter has its own ignore mask.

The two window registers are loaded through a single-word write port. A write lands on the clock edge and takes part in matching from the next cycle on. The comparison path itself is purely combinational from the access inputs and the stored windows.

Outputs give an overall hit, one hit flag per window, the index of the winning window, the pass-through address, and a 16-bit status word. In that status word the transparent bit is the only bit driven.

Top module: `ttw_matcher`

## Requirements
- R1: While reset is asserted and after it, before any write, both windows are disabled: `hit`, `win_hit`, `hit_idx`, `pass_addr` and `status` are all zero.
- R2: With `wr_en` high, `wr_data` is stored into window `wr_sel` at the rising clock edge and is used for matching from the next cycle on. The other window keeps its contents, and accesses in the write cycle still see the old contents.
- R3: Window word bit 15 enables a window. A window with bit 15 clear never reports a hit, whatever the access.
- R4: The address byte base sits in window bits 31:24 and is compared with `laddr[31:24]`. Mask bits 23:16 mark, with a 1, the address bits that are excluded from the comparison.
- R5: The function-code base sits in bits 6:4 and is compared with `fc[2:0]`. Bits 2:0 mark, with a 1, the function-code bits excluded from the comparison.
- R6: Bit 9 holds the direction to match (1 = read, matching `rd` = 1). Bit 8 set makes the direction irrelevant.
- R7: A window hits only when the address, function-code and direction comparisons all agree at once. A mismatch in any single one gives no hit.
- R8: `hit` is 1 when either window hits. `status` then has only bit 6 set (value 0x0040), and it is 0x0000 when there is no hit.
- R9: `win_hit[i]` reports window i alone. `hit_idx` is the lowest-numbered hitting window, so window 0 wins when both hit, and it is 0 when none hit.
- R10: `pass_addr` equals `laddr` when `hit` is 1 and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears both windows |
| wr_en | input | 1 | Store `wr_data` into the selected window |
| wr_sel | input | 1 | Window index for a write |
| wr_data | input | 32 | Window word to store |
| laddr | input | 32 | Logical address of the access |
| fc | input | 3 | Function code of the access |
| rd | input | 1 | Access direction, 1 = read, 0 = write |
| hit | output | 1 | Access is transparent |
| win_hit | output | 2 | Per-window hit flags |
| hit_idx | output | 1 | Lowest-numbered hitting window |
| pass_addr | output | 32 | Physical address on a hit, else zero |
| status | output | 16 | Status word, bit 6 = transparent |

## Verification
Every match output depends combinationally on the access inputs, so its value is due in the same cycle the access is presented. A window write is due one clock edge later. The bench drives each step on the falling edge and samples shortly before the next rising edge. It compares all outputs against a behavioural model that still holds the old window contents at that point. Only after that comparison does the model take the write, mirroring the one-edge delay. Directed steps probe each qualifier, the enable, the write-cycle boundary and the priority. A long pseudo-random run then compares every cycle.

// File: rtl/ttw_pkg.sv
package ttw_pkg;

    localparam int WORD_W  = 32;
    localparam int FC_W    = 3;
    localparam int BYTE_W  = 8;

    // stored form of one window; reserved word bits are not kept
    typedef struct packed {
        logic [BYTE_W-1:0] abase;    // word 31:24
        logic [BYTE_W-1:0] aign;     // word 23:16, 1 = ignore
        logic              en;       // word 15
        logic              dir_val;  // word 9, 1 = read
        logic              dir_ign;  // word 8
        logic [FC_W-1:0]   fcbase;   // word 6:4
        logic [FC_W-1:0]   fcign;    // word 2:0, 1 = ignore
    } win_t;

    function automatic win_t unpack_win(input logic [WORD_W-1:0] w);
        win_t r;
        r.abase   = w[31:24];
        r.aign    = w[23:16];
        r.en      = w[15];
        r.dir_val = w[9];
        r.dir_ign = w[8];
        r.fcbase  = w[6:4];
        r.fcign   = w[2:0];
        return r;
    endfunction

endpackage

// File: rtl/ttw_regs.sv
module ttw_regs
    import ttw_pkg::*;
#(
    parameter int NWIN = 2,
    localparam int SEL_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    output win_t              win_q [NWIN]
);

    typedef struct packed {
        win_t [NWIN-1:0] win;
    } state_t;

    state_t state_d, state_q;

    // reserved word bits are dropped on purpose
    logic unused_rsv;
    assign unused_rsv = ^{wr_data[14:10], wr_data[7], wr_data[3]};

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            for (int i = 0; i < NWIN; i++) begin
                if (wr_sel == SEL_W'(i)) begin
                    state_d.win[i] = unpack_win(wr_data);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    for (genvar g = 0; g < NWIN; g++) begin : g_out
        assign win_q[g] = state_q.win[g];
    end

    // R2: a write is visible in the selected window after the edge
    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> win_q[$past(wr_sel)] == unpack_win($past(wr_data)));

endmodule

// File: rtl/ttw_cmp.sv
module ttw_cmp
    import ttw_pkg::*;
#(
    parameter int ADDR_W = 32,
    localparam int TOP_LO = ADDR_W - BYTE_W
) (
    input  win_t              cfg,
    input  logic [ADDR_W-1:0] laddr,
    input  logic [FC_W-1:0]   fc,
    input  logic              rd,
    output logic              match
);

    logic unused_low;
    logic addr_ok, fc_ok, dir_ok;

    assign unused_low = ^laddr[TOP_LO-1:0];

    always_comb begin
        addr_ok = ((laddr[ADDR_W-1:TOP_LO] ^ cfg.abase) & ~cfg.aign) == '0;
        fc_ok   = ((fc ^ cfg.fcbase) & ~cfg.fcign) == '0;
        dir_ok  = cfg.dir_ign | (rd == cfg.dir_val);
        match   = cfg.en & addr_ok & fc_ok & dir_ok;
    end

endmodule

// File: rtl/ttw_prio.sv
module ttw_prio #(
    parameter int NWIN = 2,
    localparam int SEL_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic [NWIN-1:0]  req,
    output logic             any,
    output logic [SEL_W-1:0] idx
);

    // scan from the top so the lowest index is written last and wins
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = SEL_W'(i);
            end
        end
    end

endmodule

// File: rtl/ttw_matcher.sv
module ttw_matcher
    import ttw_pkg::*;
#(
    parameter int NWIN   = 2,
    parameter int ADDR_W = 32,
    parameter int STAT_W = 16,
    parameter int TBIT   = 6,
    localparam int SEL_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] laddr,
    input  logic [FC_W-1:0]   fc,
    input  logic              rd,
    output logic              hit,
    output logic [NWIN-1:0]   win_hit,
    output logic [SEL_W-1:0]  hit_idx,
    output logic [ADDR_W-1:0] pass_addr,
    output logic [STAT_W-1:0] status
);

    win_t win_q [NWIN];

    ttw_regs #(.NWIN(NWIN)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .win_q   (win_q)
    );

    for (genvar g = 0; g < NWIN; g++) begin : g_cmp
        ttw_cmp #(.ADDR_W(ADDR_W)) u_cmp (
            .cfg   (win_q[g]),
            .laddr (laddr),
            .fc    (fc),
            .rd    (rd),
            .match (win_hit[g])
        );

        // R3: a disabled window never hits
        assert_win_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !win_q[g].en |-> !win_hit[g]);
    end

    ttw_prio #(.NWIN(NWIN)) u_prio (
        .req (win_hit),
        .any (hit),
        .idx (hit_idx)
    );

    always_comb begin
        pass_addr = hit ? laddr : '0;
        status = '0;
        status[TBIT] = hit;
    end

    // R9: the reported window really hit, and lower windows did not
    assert_prio_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (win_hit[hit_idx] && ((win_hit & ((NWIN'(1) << hit_idx) - NWIN'(1))) == '0)));

    // R10: pass-through address tracks the logical address on a hit
    assert_pass_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> pass_addr == laddr);

    // R8: status is never nonzero without a hit
    assert_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> status == '0);

endmodule

// File: tb/ttw_matcher_tb.sv
`timescale 1ns/100ps
module ttw_matcher_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] laddr = '0;
    logic [2:0]  fc = '0;
    logic        rd = 1'b0;
    logic        hit;
    logic [1:0]  win_hit;
    logic        hit_idx;
    logic [31:0] pass_addr;
    logic [15:0] status;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;
    logic [31:0] mdl [2];

    always #2.5 clk = ~clk;

    ttw_matcher u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .laddr(laddr), .fc(fc), .rd(rd),
        .hit(hit), .win_hit(win_hit), .hit_idx(hit_idx),
        .pass_addr(pass_addr), .status(status)
    );

    function automatic bit ref_match(logic [31:0] w, logic [31:0] a, logic [2:0] f, logic r);
        if (!w[15]) return 0;
        for (int b = 0; b < 8; b++)
            if (!w[16+b] && (a[24+b] !== w[24+b])) return 0;
        for (int b = 0; b < 3; b++)
            if (!w[b] && (f[b] !== w[4+b])) return 0;
        if (!w[8] && (r !== w[9])) return 0;
        return 1;
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        bit h0, h1, any;
        h0 = ref_match(mdl[0], laddr, fc, rd);
        h1 = ref_match(mdl[1], laddr, fc, rd);
        any = h0 | h1;
        check({tag, "/R8"},  "hit",       32'(hit),       32'(any));
        check({tag, "/R9"},  "win_hit",   32'(win_hit),   {30'd0, h1, h0});
        check({tag, "/R9"},  "hit_idx",   32'(hit_idx),   (!h0 && h1) ? 32'd1 : 32'd0);
        check({tag, "/R10"}, "pass_addr", pass_addr,      any ? laddr : 32'd0);
        check({tag, "/R8"},  "status",    32'(status),    any ? 32'h40 : 32'h0);
    endtask

    task automatic step(string tag, logic we, logic sel, logic [31:0] wd,
                        logic [31:0] a, logic [2:0] f, logic r);
        @(negedge clk);
        wr_en = we; wr_sel = sel; wr_data = wd;
        laddr = a; fc = f; rd = r;
        #1.5;
        compare_all(tag);
        if (we) mdl[sel] = wd;
    endtask

    task automatic expect_hit(string tag, logic exp_hit);
        check(tag, "hit(directed)", 32'(hit), 32'(exp_hit));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        mdl[0] = '0;
        mdl[1] = '0;
        repeat (2) @(negedge clk);
        laddr = 32'h4000_0000; fc = 3'd5; rd = 1'b1;
        #1.5;
        compare_all("R1_in_reset");
        @(negedge clk);
        rst_n = 1'b1;
        step("R1_after_reset", 0, 0, 0, 32'hFFFF_FFFF, 3'd7, 1);
        step("R1_after_reset", 0, 0, 0, 32'h0000_0000, 3'd0, 0);

        // window 0: byte 0x4?, fc 5 exact, direction ignored
        step("R2_write_cycle", 1, 0, 32'h400F_8150, 32'h4A12_3456, 3'd5, 1);
        expect_hit("R2 old contents in write cycle", 0);
        step("R4_in_window", 0, 0, 0, 32'h4A12_3456, 3'd5, 1);
        expect_hit("R4 address in window", 1);
        step("R4_out_window", 0, 0, 0, 32'h5A12_3456, 3'd5, 1);
        expect_hit("R4 address outside window", 0);
        step("R5_fc_miss", 0, 0, 0, 32'h4012_3456, 3'd1, 1);
        expect_hit("R5 fc mismatch", 0);
        step("R6_dir_ignored", 0, 0, 0, 32'h4F00_0000, 3'd5, 0);
        expect_hit("R6 direction ignored", 1);

        // window 1: any address, any fc, read only
        step("R2_write_w1", 1, 1, 32'h00FF_8207, 32'h1234_5678, 3'd2, 1);
        expect_hit("R2 w1 not yet active", 0);
        step("R9_only_w1", 0, 0, 0, 32'h1234_5678, 3'd2, 1);
        check("R9 only window 1", "win_hit", 32'(win_hit), 32'd2);
        check("R9 only window 1", "hit_idx", 32'(hit_idx), 32'd1);
        step("R6_dir_miss", 0, 0, 0, 32'h1234_5678, 3'd2, 0);
        expect_hit("R6 write against read-only window", 0);
        step("R9_both", 0, 0, 0, 32'h4123_0000, 3'd5, 1);
        check("R9 both hit", "hit_idx", 32'(hit_idx), 32'd0);
        check("R8 status on hit", "status", 32'(status), 32'h40);

        // disable window 0 by clearing bit 15
        step("R3_disable", 1, 0, 32'h400F_0150, 32'h4123_0000, 3'd5, 0);
        step("R3_disabled", 0, 0, 0, 32'h4123_0000, 3'd5, 0);
        expect_hit("R3 disabled window", 0);
        check("R2 w1 kept", "win_hit", 32'(win_hit), 32'd0);
        step("R2_w1_kept", 0, 0, 0, 32'h4123_0000, 3'd5, 1);
        check("R2 w1 unaffected by w0 write", "win_hit", 32'(win_hit), 32'd2);

        // window 1: addr 0x80 exact, fc 2 exact, read
        step("R7_setup", 1, 1, 32'h8000_8220, 32'h0, 3'd0, 0);
        step("R7_all", 0, 0, 0, 32'h80AB_CDEF, 3'd2, 1);
        expect_hit("R7 all agree", 1);
        check("R10 pass addr", "pass_addr", pass_addr, 32'h80AB_CDEF);
        step("R7_addr", 0, 0, 0, 32'h81AB_CDEF, 3'd2, 1);
        expect_hit("R7 address only off", 0);
        step("R7_fc", 0, 0, 0, 32'h80AB_CDEF, 3'd3, 1);
        expect_hit("R7 fc only off", 0);
        step("R7_dir", 0, 0, 0, 32'h80AB_CDEF, 3'd2, 0);
        expect_hit("R7 direction only off", 0);
        check("R10 zero on miss", "pass_addr", pass_addr, 32'h0);

        // pseudo-random run, compared every cycle
        for (int k = 0; k < 4000; k++) begin
            logic [31:0] a, w;
            logic we;
            a = $urandom;
            w = $urandom;
            we = ($urandom % 8) == 0;
            if ($urandom % 2) a[31:24] = mdl[$urandom % 2][31:24];
            step("RND", we, 1'($urandom), w, a, 3'($urandom), 1'($urandom));
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule